// File: doc/BRIEF.md
# Ping-Pong Endpoint Buffer Manager

This block does the bookkeeping for a bulk OUT endpoint that has two packet buffers. The block does not hold any packet data. It records which buffers are occupied and the byte count of each one. It keeps two indexes: the slot the host side writes next, and the active slot that the CPU or DMA side reads. Both indexes go around a ring of `NBUF` slots, and the default is two slots.

When the serial engine reports a received packet, the block answers in the same cycle. It accepts the packet if the target slot is free, and it refuses with NAK if that slot is still occupied. Each accepted packet records its length and raises a pending endpoint interrupt. The consumer releases the active slot with a clear command. That command also moves the active index to the next slot. A clear command on an empty active slot does nothing to the state and produces a one-cycle error pulse.

Top module: `pp_ep_buf_mgr`

## Requirements
- R1: After reset, every slot is empty, the active slot index is 0, the write slot index is 0, and both `irq` and `clr_err` are 0.
- R2: A packet that is accepted marks slot `pkt_slot` occupied (bit i of `full_flags` is slot i) from the next cycle on, and sets `irq` in that same next cycle.
- R3: `pkt_slot` moves to the next slot in the ring (0, 1, ..., NBUF-1, 0) after each accepted packet, and only then. While the active slot is still occupied and unread, a second packet therefore goes to the other slot.
- R4: When the slot at `pkt_slot` is occupied, which with two slots means both are full, a packet is answered with NAK. It changes no occupancy flag, no stored length and no index.
- R5: `clr_cmd` on an occupied active slot empties that slot and moves `act_sel` to the next slot in the ring in the following cycle. `act_sel` changes at no other time.
- R6: `clr_cmd` on an empty active slot leaves all state unchanged, and `clr_err` is 1 for exactly the next cycle.
- R7: `act_len` always shows the last stored length of the slot indexed by `act_sel`.
- R8: `irq` stays at 1 until `irq_clr`. If a packet is accepted in the same cycle as `irq_clr`, `irq` stays at 1.
- R9: `pkt_ack` and `pkt_nak` depend combinationally on the cycle in which `pkt_valid` is 1. Exactly one of them is 1 when `pkt_valid` is 1, and neither is 1 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | The serial engine presents a received packet this cycle |
| pkt_len | input | LEN_W | Byte length of the presented packet |
| pkt_ack | output | 1 | Packet accepted into slot `pkt_slot` |
| pkt_nak | output | 1 | Packet refused because the slot is occupied |
| pkt_slot | output | IDX_W | Slot that the next packet is written to |
| clr_cmd | input | 1 | Consumer releases the active slot |
| irq_clr | input | 1 | Software clears the pending interrupt |
| act_sel | output | IDX_W | Active slot index for the consumer |
| act_full | output | 1 | The active slot holds a packet |
| act_len | output | LEN_W | Stored length of the active slot |
| full_flags | output | NBUF | Occupancy flag per slot |
| irq | output | 1 | Endpoint interrupt pending |
| clr_err | output | 1 | Pulse: the last clear command hit an empty slot |

## Verification
The embedded assertions check these rules on every cycle: ACK and NAK never both assert and are never missing when a packet is presented, the interrupt follows every accept, the write index advances on every accept, the active index holds still when there is no clear command, a refused packet leaves the occupancy unchanged, and a clear on an empty slot produces the error pulse. Some properties can only be shown by the bench's sequences. These are that the lengths route to the correct slot through several wraps of both indexes, that the length stored in a slot survives a refused packet, that the interrupt survives a clear request issued together with a new packet, and that a clear and an accept in the same cycle land on different slots correctly.

// File: rtl/pp_ep_pkg.sv
package pp_ep_pkg;
   // successor of a slot index on a ring of n slots
   function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction
endpackage

// File: rtl/pp_ring_ptr.sv
module pp_ring_ptr #(
   parameter int NBUF  = 2,
   parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] idx
);
   import pp_ep_pkg::*;

   if (NBUF < 2) begin : g_bad_nbuf
      $error("pp_ring_ptr: NBUF must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= '0;
      else if (adv) idx <= IDX_W'(ring_next(int'(idx), NBUF));
   end

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx) < NBUF); // R3
endmodule

// File: rtl/pp_slot_bank.sv
module pp_slot_bank #(
   parameter int NBUF  = 2,
   parameter int LEN_W = 7,
   parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [LEN_W-1:0]           wr_len,
   input  logic                       free_en,
   input  logic [IDX_W-1:0]           free_idx,
   output logic [NBUF-1:0]            full,
   output logic [NBUF-1:0][LEN_W-1:0] lens
);
   if (LEN_W < 1) begin : g_bad_len
      $error("pp_slot_bank: LEN_W must be positive");
   end

   for (genvar s = 0; s < NBUF; s++) begin : g_slot
      logic hit_wr, hit_free;
      assign hit_wr   = wr_en   && (int'(wr_idx)   == s);
      assign hit_free = free_en && (int'(free_idx) == s);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full[s] <= 1'b0;
            lens[s] <= '0;
         end else begin
            if (hit_wr) begin
               full[s] <= 1'b1;
               lens[s] <= wr_len;
            end else if (hit_free) begin
               full[s] <= 1'b0;
            end
         end
      end

      // writer only targets an empty slot; consumer only frees an occupied one
      AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
         hit_wr |-> !full[s]); // R4
      AST_FREE_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
         hit_free |-> full[s]); // R6
   end
endmodule

// File: rtl/pp_irq_latch.sv
module pp_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend <= 1'b0;
      else if (set)  pend <= 1'b1;
      else if (clr)  pend <= 1'b0;
   end

   AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pend); // R8
   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> pend); // R8
endmodule

// File: rtl/pp_ep_buf_mgr.sv
module pp_ep_buf_mgr #(
   parameter int NBUF  = 2,
   parameter int LEN_W = 7,
   localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_valid,
   input  logic [LEN_W-1:0] pkt_len,
   output logic             pkt_ack,
   output logic             pkt_nak,
   output logic [IDX_W-1:0] pkt_slot,
   input  logic             clr_cmd,
   input  logic             irq_clr,
   output logic [IDX_W-1:0] act_sel,
   output logic             act_full,
   output logic [LEN_W-1:0] act_len,
   output logic [NBUF-1:0]  full_flags,
   output logic             irq,
   output logic             clr_err
);
   logic [NBUF-1:0][LEN_W-1:0] lens;
   logic accept, release_ok;

   assign accept     = pkt_valid && !full_flags[pkt_slot];
   assign pkt_ack    = accept;
   assign pkt_nak    = pkt_valid && full_flags[pkt_slot];
   assign act_full   = full_flags[act_sel];
   assign act_len    = lens[act_sel];
   assign release_ok = clr_cmd && act_full;

   pp_ring_ptr #(.NBUF(NBUF), .IDX_W(IDX_W)) u_wr_ptr (
      .clk(clk), .rst_n(rst_n), .adv(accept), .idx(pkt_slot));

   pp_ring_ptr #(.NBUF(NBUF), .IDX_W(IDX_W)) u_rd_ptr (
      .clk(clk), .rst_n(rst_n), .adv(release_ok), .idx(act_sel));

   pp_slot_bank #(.NBUF(NBUF), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(accept), .wr_idx(pkt_slot), .wr_len(pkt_len),
      .free_en(release_ok), .free_idx(act_sel),
      .full(full_flags), .lens(lens));

   pp_irq_latch u_irq (
      .clk(clk), .rst_n(rst_n), .set(accept), .clr(irq_clr), .pend(irq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clr_err <= 1'b0;
      else        clr_err <= clr_cmd && !act_full;
   end

   AST_ACK_NAK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pkt_ack, pkt_nak})); // R9
   AST_ANSWER_GIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_ack || pkt_nak)); // R9
   AST_NAK_ALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && (&full_flags)) |-> pkt_nak); // R4
   AST_NAK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_nak && !clr_cmd) |=> $stable(full_flags)); // R4
   AST_WR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ack |=> (pkt_slot != $past(pkt_slot))); // R3
   AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ack |=> (irq && full_flags[$past(pkt_slot)])); // R2
   AST_ACT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_cmd |=> $stable(act_sel)); // R5
   AST_CLR_EMPTY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd && !act_full) |=> (clr_err && $stable(full_flags))); // R6
   AST_ERR_ONLY_ON_BAD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_cmd && !act_full) |=> !clr_err); // R6
endmodule

// File: tb/sim_pp_ep_buf_mgr.sv
module sim_pp_ep_buf_mgr;
   localparam int NBUF = 2;
   localparam int LEN_W = 7;

   typedef struct packed {
      logic             v;
      logic [LEN_W-1:0] len;
      logic             clr;
      logic             iclr;
      logic             eack;
      logic             enak;
      logic             eslot;
      logic             esel;
      logic [1:0]       efull;
      logic [LEN_W-1:0] elen;
      logic             eirq;
      logic             eerr;
   } vec_t;

   localparam int NV = 12;
   // stimulus | pre-edge answer and write slot | post-edge state
   localparam vec_t VEC [NV] = '{
      '{1'b1, 7'd10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 7'd10, 1'b1, 1'b0},
      '{1'b1, 7'd20, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 7'd10, 1'b1, 1'b0},
      '{1'b1, 7'd30, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 7'd10, 1'b1, 1'b0},
      '{1'b0, 7'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 7'd10, 1'b0, 1'b0},
      '{1'b0, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 7'd20, 1'b0, 1'b0},
      '{1'b1, 7'd40, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 7'd20, 1'b1, 1'b0},
      '{1'b0, 7'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 7'd40, 1'b0, 1'b0},
      '{1'b0, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 7'd20, 1'b0, 1'b0},
      '{1'b0, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 7'd20, 1'b0, 1'b1},
      '{1'b1, 7'd5,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 7'd5,  1'b1, 1'b0},
      '{1'b1, 7'd64, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 7'd64, 1'b1, 1'b0},
      '{1'b0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 7'd64, 1'b1, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic pkt_valid = 1'b0, clr_cmd = 1'b0, irq_clr = 1'b0;
   logic [LEN_W-1:0] pkt_len = '0;
   logic pkt_ack, pkt_nak, act_full, irq, clr_err;
   logic [0:0] pkt_slot, act_sel;
   logic [LEN_W-1:0] act_len;
   logic [NBUF-1:0] full_flags;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pp_ep_buf_mgr #(.NBUF(NBUF), .LEN_W(LEN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
      .pkt_ack(pkt_ack), .pkt_nak(pkt_nak), .pkt_slot(pkt_slot),
      .clr_cmd(clr_cmd), .irq_clr(irq_clr), .act_sel(act_sel),
      .act_full(act_full), .act_len(act_len), .full_flags(full_flags),
      .irq(irq), .clr_err(clr_err));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_reset_state(input string tag);
      chk("R1", {tag, " full_flags"}, int'(full_flags), 0);
      chk("R1", {tag, " act_sel"}, int'(act_sel), 0);
      chk("R1", {tag, " pkt_slot"}, int'(pkt_slot), 0);
      chk("R1", {tag, " irq"}, int'(irq), 0);
      chk("R1", {tag, " clr_err"}, int'(clr_err), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_reset_state("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_reset_state("after reset");

      for (int i = 0; i < NV; i++) begin
         pkt_valid = VEC[i].v;
         pkt_len   = VEC[i].len;
         clr_cmd   = VEC[i].clr;
         irq_clr   = VEC[i].iclr;
         #1;
         chk("R9", $sformatf("v%0d ack", i), int'(pkt_ack), int'(VEC[i].eack));
         chk("R4", $sformatf("v%0d nak", i), int'(pkt_nak), int'(VEC[i].enak));
         chk("R3", $sformatf("v%0d pkt_slot", i), int'(pkt_slot), int'(VEC[i].eslot));
         @(posedge clk);
         #1;
         pkt_valid = 1'b0; clr_cmd = 1'b0; irq_clr = 1'b0;
         chk("R5", $sformatf("v%0d act_sel", i), int'(act_sel), int'(VEC[i].esel));
         chk("R2", $sformatf("v%0d full_flags", i), int'(full_flags), int'(VEC[i].efull));
         chk("R7", $sformatf("v%0d act_len", i), int'(act_len), int'(VEC[i].elen));
         chk("R8", $sformatf("v%0d irq", i), int'(irq), int'(VEC[i].eirq));
         chk("R6", $sformatf("v%0d clr_err", i), int'(clr_err), int'(VEC[i].eerr));
         @(negedge clk);
      end

      // directed: one idle cycle after a bad clear, the error pulse is gone (R6)
      chk("R6", "clr_err idle", int'(clr_err), 0);
      // directed: interrupt held without irq_clr across idle cycles (R8)
      repeat (3) @(negedge clk);
      chk("R8", "irq held", int'(irq), 1);
      // directed: idle keeps act_full consistent with stored slot (R7)
      chk("R7", "act_full slot0", int'(act_full), 1);
      // directed: reset in the middle of a run restores the initial state (R1)
      rst_n = 1'b0;
      #1;
      chk_reset_state("mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "act_full after reset", int'(act_full), 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule